// File: doc/BRIEF.md
# Write Strobe Qualifier with Supply Lockout

This block sits between the active-low parallel bus controls of a byte-wide non-volatile memory (chip select, write enable, output enable) and the engine that performs the write. A fast sampling clock oversamples the controls after a two-flop synchronizer. The block combines chip select and write enable into one write strobe and rejects strobes that are too short. It takes the address at the start of the strobe and the data at its end, then issues a single-cycle byte-load pulse that carries the captured address and data.

Writes are refused while output enable is low and while the supply-sense input reports an undervoltage. After the supply returns, writes stay refused for a programmable hold-off. A supply dip during the hold-off starts it again from zero. Address and data travel through a two-stage alignment pipeline, so they reach the strobe logic in the same cycle as the synchronized controls.

Top module: `wstrb_qualifier`

## Requirements
- R1: A write strobe exists only while output enable (`oe_n`) is high and both `cs_n` and `we_n` are low. The earlier of `cs_n`/`we_n` rising ends it, and `load_pulse` goes high on the third rising clock edge after that input change.
- R2: `load_addr` holds the address that was present when the later of `cs_n`/`we_n` went low. Address changes during the strobe are ignored.
- R3: `load_data` holds the data present in the last sample before the earlier of `cs_n`/`we_n` rose. Data changed together with that rise is not taken.
- R4: A strobe shorter than `MIN_W` samples gives no load pulse and leaves `load_addr`/`load_data` unchanged. A strobe of exactly `MIN_W` samples gives a pulse.
- R5: While `oe_n` is low, no write starts. If `oe_n` falls during a strobe, that strobe is dropped without a pulse.
- R6: While `supply_ok` is low, no load pulse is produced.
- R7: After `supply_ok` rises, writes stay blocked for `PWR_DLY` sample cycles and are then accepted.
- R8: If `supply_ok` falls during the hold-off, the hold-off restarts from zero once the supply returns.
- R9: After reset, `load_pulse`, `load_addr` and `load_data` are all zero.
- R10: `load_pulse` lasts exactly one cycle. `load_addr` and `load_data` change only in the cycle in which `load_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| supply_ok | input | 1 | Supply above threshold when high |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| load_pulse | output | 1 | One-cycle byte-load request |
| load_addr | output | AW | Captured address |
| load_data | output | DW | Captured data |

## Verification
Random strobes vary which of chip select or write enable falls last and which rises first. They also vary the overlap width, so the bench can tell capture at the later fall apart from capture at the earlier fall, and capture at the last active sample apart from capture at the first. Widths just below, at, and above `MIN_W` separate a filter that counts samples from one that is off by one. Directed sequences lower output enable in the middle of a strobe, write during undervoltage, and interrupt the hold-off with a supply dip. These show whether the lockout counter restarts rather than pauses.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // next value of a counter that stops at its ceiling
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction

  // true when a strobe of 'samples' length is long enough to be a write
  function automatic logic wide_enough(input int unsigned samples, input int unsigned min_w);
    return samples >= min_w;
  endfunction
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int        W      = 1,
  parameter int        STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_VAL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wq_power_gate.sv
module wq_power_gate #(
  parameter int PWR_DLY = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok,
  output logic locked
);
  import wq_pkg::*;
  localparam int CW = $clog2(PWR_DLY + 1);

  logic [CW-1:0] dly_cnt;
  logic          dly_done;

  assign dly_done = (dly_cnt == CW'(PWR_DLY));
  assign locked   = !(sup_ok && dly_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dly_cnt <= '0;
    else if (!sup_ok) dly_cnt <= '0;
    else              dly_cnt <= CW'(sat_next(int'(dly_cnt), PWR_DLY));
  end

  AST_DIP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (dly_cnt == '0)); // R8
  AST_LOW_SUPPLY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> locked); // R6
endmodule

// File: rtl/wq_strobe_core.sv
module wq_strobe_core #(
  parameter int AW    = 17,
  parameter int DW    = 8,
  parameter int MIN_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_cs_n,
  input  logic          s_we_n,
  input  logic          s_oe_n,
  input  logic          locked,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_din,
  output logic          load_pulse,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);
  import wq_pkg::*;
  localparam int NW = $clog2(MIN_W + 1);

  logic          both_low, strobe, strobe_q, go, run;
  logic          strobe_start, strobe_end_ok;
  logic [NW-1:0] run_len;
  logic [AW-1:0] addr_hold;
  logic [DW-1:0] data_last;

  assign both_low      = !s_cs_n && !s_we_n;
  assign strobe        = both_low && s_oe_n;
  assign go            = strobe && !locked;
  assign strobe_start  = go && !strobe_q;
  assign strobe_end_ok = run && !both_low && s_oe_n && !locked &&
                         wide_enough(int'(run_len), MIN_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      run       <= 1'b0;
      run_len   <= '0;
      addr_hold <= '0;
      data_last <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe_start) begin
        run       <= 1'b1;
        run_len   <= NW'(1);
        addr_hold <= s_addr;
        data_last <= s_din;
      end else if (run && go) begin
        run_len   <= NW'(sat_next(int'(run_len), MIN_W));
        data_last <= s_din;
      end else begin
        run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pulse <= 1'b0;
      load_addr  <= '0;
      load_data  <= '0;
    end else begin
      load_pulse <= strobe_end_ok;
      if (strobe_end_ok) begin
        load_addr <= addr_hold;
        load_data <= data_last;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R10
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> ($stable(load_addr) && $stable(load_data))); // R10
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !s_oe_n |=> !load_pulse); // R5
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !load_pulse); // R6
endmodule

// File: rtl/wstrb_qualifier.sv
module wstrb_qualifier #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int MIN_W   = 3,
  parameter int PWR_DLY = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          supply_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          load_pulse,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);
  logic [3:0]       ctl_s;
  logic [AW+DW-1:0] bus_s;
  logic             locked;

  // controls: {supply, oe, we, cs}; idle = supply low, oe low, we/cs high
  wq_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0011)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok, oe_n, we_n, cs_n}), .q(ctl_s));

  wq_sync #(.W(AW+DW), .STAGES(2), .RST_VAL('0)) u_bus_align (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s));

  wq_power_gate #(.PWR_DLY(PWR_DLY)) u_power (
    .clk(clk), .rst_n(rst_n), .sup_ok(ctl_s[3]), .locked(locked));

  wq_strobe_core #(.AW(AW), .DW(DW), .MIN_W(MIN_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(ctl_s[0]), .s_we_n(ctl_s[1]), .s_oe_n(ctl_s[2]),
    .locked(locked),
    .s_addr(bus_s[AW+DW-1:DW]), .s_din(bus_s[DW-1:0]),
    .load_pulse(load_pulse), .load_addr(load_addr), .load_data(load_data));
endmodule

// File: tb/wstrb_qualifier_test.sv
`timescale 1ns/1ps
module wstrb_qualifier_test;
  localparam int AW = 17, DW = 8, MIN_W = 3, PWR_DLY = 200;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, oe_n = 1, supply_ok = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic load_pulse;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  int checks = 0, fails = 0, pulses = 0;
  logic prev_pulse = 0;

  always #5 clk = ~clk;

  wstrb_qualifier #(.AW(AW), .DW(DW), .MIN_W(MIN_W), .PWR_DLY(PWR_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .supply_ok(supply_ok), .addr(addr), .din(din),
    .load_pulse(load_pulse), .load_addr(load_addr), .load_data(load_data));

  function automatic logic expect_pulse(input int w);
    return w >= MIN_W;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: count pulses, flag pulses longer than a cycle (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_pulse) pulses++;
      if (load_pulse && prev_pulse) begin
        checks++; fails++;
        $display("FAIL R10 actual=2-cycle pulse expected=1-cycle");
      end
      prev_pulse = load_pulse;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // strobe: cs/we fall in given order, overlap w cycles, rise in given order
  task automatic strobe(input logic we_last, input int lag, input int w,
                        input logic we_first_up, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    @(negedge clk);
    addr = $urandom; din = $urandom;
    if (we_last) cs_n = 0; else we_n = 0;
    idle(lag);
    addr = a; din = $urandom;
    if (we_last) we_n = 0; else cs_n = 0;
    if (w >= 2) begin idle(1); addr = $urandom; din = d; idle(w - 1); end
    else begin din = d; idle(w); end
    addr = $urandom; din = $urandom;
    if (we_first_up) we_n = 1; else cs_n = 1;
    idle(1);
    cs_n = 1; we_n = 1;
    idle(5);
  endtask

  task automatic write_expect(input string req, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input logic ok);
    int p0;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    p0 = pulses; a0 = load_addr; d0 = load_data;
    strobe($urandom_range(0,1), $urandom_range(0,2), MIN_W + 1, $urandom_range(0,1), a, d);
    check(req, pulses - p0, ok ? 1 : 0);
    check(req, load_addr, ok ? a : a0);
    check(req, load_data, ok ? d : d0);
  endtask

  initial begin : watchdog
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idle(3);
    // R9 reset state
    check("R9", load_pulse, 0);
    check("R9", load_addr, 0);
    check("R9", load_data, 0);
    rst_n = 1;
    idle(PWR_DLY + 10);

    // R1 latency: pulse on third rising edge after strobe ends
    @(negedge clk); addr = 17'h1234; din = 8'h5a; cs_n = 0; we_n = 0;
    idle(MIN_W + 1);
    cs_n = 1; we_n = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 early", load_pulse, 0);
    @(posedge clk); #1;
    check("R1 on time", load_pulse, 1);
    check("R2", load_addr, 17'h1234);
    check("R3", load_data, 8'h5a);
    idle(5);

    // R1/R2/R3/R4 random strobes with varied ordering and width
    for (int k = 0; k < 60; k++) begin
      int w, p0;
      logic [AW-1:0] a, a0;
      logic [DW-1:0] d, d0;
      w = $urandom_range(1, MIN_W + 3);
      a = $urandom; d = $urandom;
      p0 = pulses; a0 = load_addr; d0 = load_data;
      strobe($urandom_range(0,1), $urandom_range(0,3), w, $urandom_range(0,1), a, d);
      check("R4 count", pulses - p0, expect_pulse(w) ? 1 : 0);
      check("R2 addr", load_addr, expect_pulse(w) ? a : a0);
      check("R3 data", load_data, expect_pulse(w) ? d : d0);
    end

    // R4 boundaries
    begin
      int p0;
      p0 = pulses;
      strobe(1, 1, MIN_W - 1, 0, 17'h0aaaa, 8'h11);
      check("R4 below min", pulses - p0, 0);
      strobe(0, 1, MIN_W, 1, 17'h15555, 8'h22);
      check("R4 at min", pulses - p0, 1);
      check("R4 at min addr", load_addr, 17'h15555);
    end

    // R5 oe low throughout, then oe falls mid-strobe
    oe_n = 0;
    write_expect("R5 oe low", 17'h00f0f, 8'h33, 0);
    oe_n = 1;
    begin
      int p0;
      p0 = pulses;
      @(negedge clk); cs_n = 0; we_n = 0; addr = 17'h1; din = 8'h44;
      idle(MIN_W + 1); oe_n = 0; idle(2); cs_n = 1; we_n = 1; idle(2); oe_n = 1; idle(5);
      check("R5 oe mid", pulses - p0, 0);
    end

    // R6 supply low
    supply_ok = 0; idle(4);
    write_expect("R6 low supply", 17'h00777, 8'h55, 0);
    // R7 hold-off
    supply_ok = 1; idle(PWR_DLY - 60);
    write_expect("R7 still locked", 17'h00888, 8'h66, 0);
    idle(60);
    write_expect("R7 released", 17'h00999, 8'h77, 1);

    // R8 dip restarts hold-off
    supply_ok = 0; idle(4); supply_ok = 1;
    idle(PWR_DLY - 60);
    supply_ok = 0; idle(2); supply_ok = 1;
    idle(PWR_DLY - 60);
    write_expect("R8 restarted", 17'h00abc, 8'h88, 0);
    idle(70);
    write_expect("R8 released", 17'h00def, 8'h99, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule